// File: doc/BRIEF.md
# Duplicate Tag Snoop Filter

This block keeps a second copy of the tag table of a direct-mapped, write-back module cache. Traffic that other processor modules put on the system bus is checked against this copy. The processor's own tag lookup is never disturbed by a snoop. Each snoop takes an address from the bus snoop lines and a bus command. The block looks up the copy at the index taken from that address. When the block is present and the command targets memory, it raises a shared response for one cycle.

The copy follows the primary tag store through update requests. A fill request writes the block address of the new line and sets the entry's valid bit. It does this on the same edge that the local fill commits its tag. An evict request clears the valid bit at the index. Addresses are 36-bit physical addresses split into 64-byte blocks. The index is taken from the bits just above the block offset, and the remaining high bits are stored as the tag. When an update and a snoop land on the same index in one cycle, the update takes effect first, so the snoop result reflects the new entry.

Top module: `dup_tag_snoop_filter`

## Requirements
- R1: After reset every entry is invalid, `shared_o` is low, and no snoop hits until a fill has been applied.
- R2: A memory read snoop (command 4'h1) sampled on a rising edge with `snp_valid_i` high, whose block hits, drives `shared_o` high in the following cycle only. It is low again one cycle later unless another hit follows.
- R3: A snoop hits only when the indexed entry is valid and its stored tag equals the snooped tag bits [35:14]. The same index with a different tag gives no shared response.
- R4: The block offset bits [5:0] take no part in the lookup. Any byte address inside a cached 64-byte block hits.
- R5: An evict request (`upd_fill_i` low) clears the entry at index bits [13:6]. A later snoop of that block gives no shared response.
- R6: When an update and a snoop use the same index in one cycle, the snoop sees the updated entry. A same-cycle fill of the snooped block gives a hit, and a same-cycle evict gives a miss.
- R7: I/O read (4'h5), I/O write (4'h6) and every command other than 4'h1 and 4'h2 never produce a shared response, even for a cached block.
- R8: A memory write snoop (command 4'h2) that hits drives `shared_o` exactly as a memory read does (default `SHARE_ON_WRITE` = 1).
- R9: A fill to an index replaces the tag held there. The earlier block at that index stops hitting, and the new block hits.
- R10: With `snp_valid_i` low, the snoop command and address have no effect: `shared_o` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid_i | input | 1 | Update request from the primary tag store |
| upd_fill_i | input | 1 | 1 = fill (write tag, set valid), 0 = evict (clear valid) |
| upd_addr_i | input | 36 | Physical address of the line being filled or evicted |
| snp_valid_i | input | 1 | Snoop address and command are valid this cycle |
| snp_cmd_i | input | 4 | Snooped bus command (4'h1 memory read, 4'h2 memory write, 4'h5 I/O read, 4'h6 I/O write) |
| snp_addr_i | input | 36 | Snooped physical address |
| shared_o | output | 1 | Shared response, one cycle after a qualifying hit |

## Verification
The assertions assume an evict is issued only for an index the primary store holds. They assume an update never arrives during reset. They also assume the snoop command is stable only while `snp_valid_i` is high, so `$past` looks only at cycles in which the inputs were driven. The bench drives every input on the falling edge and holds each request for exactly one cycle. It keeps all inputs low during reset and fills an index before it evicts it. The same-index collision cases are made by raising an update and a snoop in the same cycle.

// File: rtl/dts_pkg.sv
package dts_pkg;

   localparam logic [3:0] CMD_NOP    = 4'h0;
   localparam logic [3:0] CMD_MEM_RD = 4'h1;
   localparam logic [3:0] CMD_MEM_WR = 4'h2;
   localparam logic [3:0] CMD_IO_RD  = 4'h5;
   localparam logic [3:0] CMD_IO_WR  = 4'h6;

   typedef enum logic [1:0] {
      CLS_NONE   = 2'd0,
      CLS_MEM_RD = 2'd1,
      CLS_MEM_WR = 2'd2,
      CLS_IO     = 2'd3
   } cmd_class_e;

   function automatic cmd_class_e classify(input logic [3:0] cmd);
      case (cmd)
         CMD_MEM_RD: classify = CLS_MEM_RD;
         CMD_MEM_WR: classify = CLS_MEM_WR;
         CMD_IO_RD,
         CMD_IO_WR:  classify = CLS_IO;
         default:    classify = CLS_NONE;
      endcase
   endfunction

endpackage

// File: rtl/dts_addr_split.sv
module dts_addr_split #(
   parameter int ADDR_W = 36,
   parameter int OFF_W  = 6,
   parameter int IDX_W  = 8,
   localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic [IDX_W-1:0]  idx_o,
   output logic [TAG_W-1:0]  tag_o
);

   generate
      if (TAG_W < 1) begin : g_bad_split
         $error("dts_addr_split: offset and index leave no tag bits");
      end
   endgenerate

   assign idx_o = addr_i[OFF_W +: IDX_W];
   assign tag_o = addr_i[ADDR_W-1 -: TAG_W];

endmodule

// File: rtl/dts_cmd_qual.sv
module dts_cmd_qual
   import dts_pkg::*;
#(
   parameter bit SHARE_ON_WRITE = 1'b1
) (
   input  logic       valid_i,
   input  logic [3:0] cmd_i,
   output logic       elig_o
);

   cmd_class_e cls;
   assign cls = classify(cmd_i);

   generate
      if (SHARE_ON_WRITE) begin : g_rd_wr
         assign elig_o = valid_i && ((cls == CLS_MEM_RD) || (cls == CLS_MEM_WR));
      end else begin : g_rd_only
         assign elig_o = valid_i && (cls == CLS_MEM_RD);
      end
   endgenerate

endmodule

// File: rtl/dts_tag_store.sv
module dts_tag_store #(
   parameter int IDX_W = 8,
   parameter int TAG_W = 22,
   localparam int DEPTH = 1 << IDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en_i,
   input  logic             wr_valid_i,
   input  logic [IDX_W-1:0] wr_idx_i,
   input  logic [TAG_W-1:0] wr_tag_i,
   input  logic [IDX_W-1:0] rd_idx_i,
   output logic             rd_valid_o,
   output logic [TAG_W-1:0] rd_tag_o
);

   generate
      if (IDX_W < 1 || IDX_W > 12) begin : g_bad_depth
         $error("dts_tag_store: IDX_W must lie in 1..12");
      end
   endgenerate

   logic [DEPTH-1:0] vld_w;
   logic [TAG_W-1:0] tag_w [DEPTH];

   generate
      for (genvar e = 0; e < DEPTH; e++) begin : g_ent
         logic             v_q;
         logic [TAG_W-1:0] t_q;
         logic             hit_wr;
         assign hit_wr = wr_en_i && (wr_idx_i == IDX_W'(e));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               v_q <= 1'b0;
            end else if (hit_wr) begin
               v_q <= wr_valid_i;
            end
         end

         always_ff @(posedge clk) begin
            if (hit_wr && wr_valid_i) begin
               t_q <= wr_tag_i;
            end
         end

         assign vld_w[e] = v_q;
         assign tag_w[e] = t_q;
      end
   endgenerate

   // Update forwarding: a write to the read index wins over stored contents.
   logic fwd;
   assign fwd = wr_en_i && (wr_idx_i == rd_idx_i);

   always_comb begin
      if (fwd) begin
         rd_valid_o = wr_valid_i;
         rd_tag_o   = wr_tag_i;
      end else begin
         rd_valid_o = vld_w[rd_idx_i];
         rd_tag_o   = tag_w[rd_idx_i];
      end
   end

   // R5: an entry just cleared reads back invalid when not rewritten.
   a_r5_evict_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !wr_valid_i) |=>
         (wr_en_i || (rd_idx_i != $past(wr_idx_i)) || !rd_valid_o));

endmodule

// File: rtl/dts_resp.sv
module dts_resp #(
   parameter int TAG_W = 22
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             elig_i,
   input  logic             ent_valid_i,
   input  logic [TAG_W-1:0] ent_tag_i,
   input  logic [TAG_W-1:0] snp_tag_i,
   output logic             shared_o
);

   logic hit;
   assign hit = elig_i && ent_valid_i && (ent_tag_i == snp_tag_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shared_o <= 1'b0;
      end else begin
         shared_o <= hit;
      end
   end

   // R3: a response follows only a matching valid entry.
   a_r3_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
      shared_o |-> $past(ent_valid_i && (ent_tag_i == snp_tag_i)));

endmodule

// File: rtl/dup_tag_snoop_filter.sv
module dup_tag_snoop_filter
   import dts_pkg::*;
#(
   parameter int ADDR_W         = 36,
   parameter int OFF_W          = 6,
   parameter int IDX_W          = 8,
   parameter bit SHARE_ON_WRITE = 1'b1,
   localparam int TAG_W         = ADDR_W - OFF_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_valid_i,
   input  logic              upd_fill_i,
   input  logic [ADDR_W-1:0] upd_addr_i,
   input  logic              snp_valid_i,
   input  logic [3:0]        snp_cmd_i,
   input  logic [ADDR_W-1:0] snp_addr_i,
   output logic              shared_o
);

   generate
      if (ADDR_W < OFF_W + IDX_W + 1) begin : g_bad_addr
         $error("dup_tag_snoop_filter: address too narrow");
      end
   endgenerate

   logic [IDX_W-1:0] upd_idx, snp_idx;
   logic [TAG_W-1:0] upd_tag, snp_tag;
   logic             elig;
   logic             ent_valid;
   logic [TAG_W-1:0] ent_tag;

   dts_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_upd_split (
      .addr_i (upd_addr_i),
      .idx_o  (upd_idx),
      .tag_o  (upd_tag)
   );

   dts_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_snp_split (
      .addr_i (snp_addr_i),
      .idx_o  (snp_idx),
      .tag_o  (snp_tag)
   );

   dts_cmd_qual #(.SHARE_ON_WRITE(SHARE_ON_WRITE)) u_qual (
      .valid_i (snp_valid_i),
      .cmd_i   (snp_cmd_i),
      .elig_o  (elig)
   );

   dts_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en_i    (upd_valid_i),
      .wr_valid_i (upd_fill_i),
      .wr_idx_i   (upd_idx),
      .wr_tag_i   (upd_tag),
      .rd_idx_i   (snp_idx),
      .rd_valid_o (ent_valid),
      .rd_tag_o   (ent_tag)
   );

   dts_resp #(.TAG_W(TAG_W)) u_resp (
      .clk         (clk),
      .rst_n       (rst_n),
      .elig_i      (elig),
      .ent_valid_i (ent_valid),
      .ent_tag_i   (ent_tag),
      .snp_tag_i   (snp_tag),
      .shared_o    (shared_o)
   );

   // R2 / R10: a response needs a sampled snoop in the previous cycle.
   a_r2_follows_snoop: assert property (@(posedge clk) disable iff (!rst_n)
      shared_o |-> $past(snp_valid_i));

   // R7: I/O space commands never answer shared.
   a_r7_io_silent: assert property (@(posedge clk) disable iff (!rst_n)
      $past(snp_valid_i && ((snp_cmd_i == CMD_IO_RD) || (snp_cmd_i == CMD_IO_WR)))
         |-> !shared_o);

   // R6: a same-cycle fill of the snooped block is seen by the snoop.
   a_r6_fill_first: assert property (@(posedge clk) disable iff (!rst_n)
      $past(upd_valid_i && upd_fill_i && snp_valid_i && (snp_cmd_i == CMD_MEM_RD) &&
            (snp_addr_i[ADDR_W-1:OFF_W] == upd_addr_i[ADDR_W-1:OFF_W]))
         |-> shared_o);

   // R6: a same-cycle evict at the snooped index hides the entry.
   a_r6_evict_first: assert property (@(posedge clk) disable iff (!rst_n)
      $past(upd_valid_i && !upd_fill_i && snp_valid_i &&
            (snp_addr_i[OFF_W +: IDX_W] == upd_addr_i[OFF_W +: IDX_W]))
         |-> !shared_o);

endmodule

// File: tb/dup_tag_snoop_filter_tb.sv
module dup_tag_snoop_filter_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        upd_valid_i = 1'b0;
   logic        upd_fill_i = 1'b0;
   logic [35:0] upd_addr_i = '0;
   logic        snp_valid_i = 1'b0;
   logic [3:0]  snp_cmd_i = '0;
   logic [35:0] snp_addr_i = '0;
   logic        shared_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   dup_tag_snoop_filter u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .upd_valid_i (upd_valid_i),
      .upd_fill_i  (upd_fill_i),
      .upd_addr_i  (upd_addr_i),
      .snp_valid_i (snp_valid_i),
      .snp_cmd_i   (snp_cmd_i),
      .snp_addr_i  (snp_addr_i),
      .shared_o    (shared_o)
   );

   function automatic logic [35:0] mk(input logic [21:0] tag, input logic [7:0] idx,
                                      input logic [5:0] off);
      return {tag, idx, off};
   endfunction

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: shared_o=%b expected %b", req, act, exp);
      end
   endtask

   task automatic do_update(input logic fill, input logic [35:0] a);
      @(negedge clk);
      upd_valid_i = 1'b1; upd_fill_i = fill; upd_addr_i = a;
      @(negedge clk);
      upd_valid_i = 1'b0; upd_fill_i = 1'b0;
   endtask

   // Snoop sampled at the next rising edge; response checked in the cycle after,
   // then checked low one cycle later.
   task automatic do_snoop(input string req, input logic v, input logic [3:0] cmd,
                           input logic [35:0] a, input logic exp);
      @(negedge clk);
      snp_valid_i = v; snp_cmd_i = cmd; snp_addr_i = a;
      @(negedge clk);
      snp_valid_i = 1'b0; snp_cmd_i = 4'h0;
      check(req, shared_o, exp);
      @(negedge clk);
      check({req, " one-cycle"}, shared_o, 1'b0);
   endtask

   task automatic do_collide(input string req, input logic fill, input logic [35:0] ua,
                             input logic [35:0] sa, input logic exp);
      @(negedge clk);
      upd_valid_i = 1'b1; upd_fill_i = fill; upd_addr_i = ua;
      snp_valid_i = 1'b1; snp_cmd_i = 4'h1; snp_addr_i = sa;
      @(negedge clk);
      upd_valid_i = 1'b0; upd_fill_i = 1'b0;
      snp_valid_i = 1'b0; snp_cmd_i = 4'h0;
      check(req, shared_o, exp);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset", shared_o, 1'b0);
      do_snoop("R1 empty", 1'b1, 4'h1, mk(22'h0, 8'h00, 6'h0), 1'b0);
      do_snoop("R1 empty2", 1'b1, 4'h1, mk(22'h12345, 8'h3C, 6'h0), 1'b0);
   endtask

   task automatic t_basic_hit();
      do_update(1'b1, mk(22'h12345, 8'h3C, 6'h10));
      do_snoop("R2 read hit", 1'b1, 4'h1, mk(22'h12345, 8'h3C, 6'h10), 1'b1);
      do_snoop("R4 offset", 1'b1, 4'h1, mk(22'h12345, 8'h3C, 6'h3F), 1'b1);
      do_snoop("R4 offset0", 1'b1, 4'h1, mk(22'h12345, 8'h3C, 6'h00), 1'b1);
      do_snoop("R3 tag mismatch", 1'b1, 4'h1, mk(22'h12344, 8'h3C, 6'h10), 1'b0);
      do_snoop("R3 index mismatch", 1'b1, 4'h1, mk(22'h12345, 8'h3D, 6'h10), 1'b0);
   endtask

   task automatic t_commands();
      do_snoop("R8 mem write", 1'b1, 4'h2, mk(22'h12345, 8'h3C, 6'h0), 1'b1);
      do_snoop("R7 io read", 1'b1, 4'h5, mk(22'h12345, 8'h3C, 6'h0), 1'b0);
      do_snoop("R7 io write", 1'b1, 4'h6, mk(22'h12345, 8'h3C, 6'h0), 1'b0);
      do_snoop("R7 other cmd", 1'b1, 4'hF, mk(22'h12345, 8'h3C, 6'h0), 1'b0);
      do_snoop("R7 nop", 1'b1, 4'h0, mk(22'h12345, 8'h3C, 6'h0), 1'b0);
      do_snoop("R10 not valid", 1'b0, 4'h1, mk(22'h12345, 8'h3C, 6'h0), 1'b0);
   endtask

   task automatic t_back_to_back();
      @(negedge clk);
      snp_valid_i = 1'b1; snp_cmd_i = 4'h1; snp_addr_i = mk(22'h12345, 8'h3C, 6'h0);
      @(negedge clk);
      snp_addr_i = mk(22'h00001, 8'h3C, 6'h0);
      check("R2 first of pair", shared_o, 1'b1);
      @(negedge clk);
      snp_valid_i = 1'b0; snp_cmd_i = 4'h0;
      check("R3 second of pair miss", shared_o, 1'b0);
      @(negedge clk);
   endtask

   task automatic t_replace_evict();
      do_update(1'b1, mk(22'h2AAAA, 8'h3C, 6'h0));
      do_snoop("R9 old block gone", 1'b1, 4'h1, mk(22'h12345, 8'h3C, 6'h0), 1'b0);
      do_snoop("R9 new block hits", 1'b1, 4'h1, mk(22'h2AAAA, 8'h3C, 6'h0), 1'b1);
      do_update(1'b1, mk(22'h00777, 8'h81, 6'h0));
      do_update(1'b0, mk(22'h2AAAA, 8'h3C, 6'h0));
      do_snoop("R5 evicted", 1'b1, 4'h1, mk(22'h2AAAA, 8'h3C, 6'h0), 1'b0);
      do_snoop("R5 other index kept", 1'b1, 4'h1, mk(22'h00777, 8'h81, 6'h0), 1'b1);
   endtask

   task automatic t_collide();
      do_collide("R6 fill same cycle", 1'b1, mk(22'h3C0DE, 8'hF0, 6'h0),
                 mk(22'h3C0DE, 8'hF0, 6'h8), 1'b1);
      @(negedge clk);
      check("R2 collision one-cycle", shared_o, 1'b0);
      do_collide("R6 evict same cycle", 1'b0, mk(22'h3C0DE, 8'hF0, 6'h0),
                 mk(22'h3C0DE, 8'hF0, 6'h0), 1'b0);
      do_collide("R6 fill other tag same cycle", 1'b1, mk(22'h11111, 8'h81, 6'h0),
                 mk(22'h00777, 8'h81, 6'h0), 1'b0);
      do_snoop("R9 fill via collision", 1'b1, 4'h1, mk(22'h11111, 8'h81, 6'h0), 1'b1);
   endtask

   initial begin
      t_reset();
      t_basic_hit();
      t_commands();
      t_back_to_back();
      t_replace_evict();
      t_collide();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule